// File: doc/BRIEF.md
# Bitmap Cursor Overlay

This block lays a small two-bit-per-pixel cursor image over a live stream of 24-bit RGB pixels. The pixel stream arrives one pixel per valid cycle, with strobes marking the first pixel of each line and of each frame. From these strobes the block tracks its own screen coordinates. It decides for every pixel whether the pixel lies under the cursor. If it does, the pixel is replaced by one of two stored colours or by its own complement, or it is left alone, according to the cursor image and a mode bit. Every pixel leaves the block exactly one clock after it enters.

All settings go through one byte-wide register write port. The cursor image is held in a 256-byte internal store. It is filled by first loading an address pointer and then streaming data bytes, and the pointer steps forward after each byte. The cursor is placed by a 10-bit position and a 5-bit hot spot on each axis. The hot spot names the image pixel that lands on the position. In interlaced operation the block counts fields itself, so alternate cursor rows appear in alternate fields.

Top module: `cursor_overlay`

## Requirements
- R1: During and after reset, out_valid is 0 and out_rgb is 0. The control register resets to 0, so the overlay starts disabled.
- R2: out_valid equals pix_valid delayed by one clock. out_rgb changes only in the cycle after a valid input pixel and otherwise holds its value.
- R3: While the enable bit is 0, each output pixel equals the input pixel of the previous cycle, with the same one-clock latency.
- R4: With the mode bit at 0, the codes map as follows: 00 gives colour two, 01 gives colour one, 10 lets the input pixel through, and 11 gives the inverted input pixel.
- R5: With the mode bit at 1, the codes map as follows: 00 lets the input pixel through, 01 gives the inverted input pixel, 10 gives colour one, and 11 gives colour two.
- R6: Inversion complements all 24 bits, which means each 8-bit component is complemented.
- R7: Cursor image pixel (row r, column c) covers screen pixel (xpos − xhot + c, ypos − yhot + r). No pixel outside that 32×32 square is touched.
- R8: Image pixels whose screen coordinate would be negative are dropped, and the rest of the image is still shown in place.
- R9: Image byte address = row·8 + column/4. Inside a byte, the leftmost of the four pixels sits in bits [7:6] and the rightmost in bits [1:0].
- R10: A write to register 13 loads the image pointer. Each write to register 14 stores the byte at the pointer and then increments the pointer, which wraps from 255 to 0.
- R11: When the interlace bit is 1, the first frame after reset is field 0 and the field toggles with every frame strobe. Line n of a field is screen line 2n + field.
- R12: A frame strobe sets x and y to 0. A line strobe alone sets x to 0 and advances y by one. Each valid pixel advances x by one.
- R13: The register addresses are as follows. 0 is control, with bit 0 enable, bit 1 mode and bit 2 interlace. 1 and 2 are xpos low and high. 3 and 4 are ypos low and high. 5 is xhot and 6 is yhot. 7, 8 and 9 are colour one red, green and blue. 10, 11 and 12 are colour two red, green and blue. A write takes effect from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 8 | Register write byte |
| pix_valid | input | 1 | Input pixel valid |
| line_start | input | 1 | First pixel of a line (with pix_valid) |
| frame_start | input | 1 | First pixel of a frame (with pix_valid) |
| pix_rgb | input | 24 | Input pixel, red in [23:16] |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Output pixel, red in [23:16] |

## Verification
A wrong coordinate counter or a wrong field bit moves the whole cursor image. That shows up on the first cursor pixel of the next frame, either as colour where the input should pass or as the input where colour was expected. A bad image pointer or a bad byte layout shows as the wrong code on one cursor pixel in the same clock that pixel is output. A latency or hold fault shows on out_valid or out_rgb in the very next cycle. The bench compares every output pixel of whole frames against an independent model, so any of these faults is caught within one frame.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

    typedef enum logic [1:0] {
        ACT_PASS = 2'd0,
        ACT_INV  = 2'd1,
        ACT_COL1 = 2'd2,
        ACT_COL2 = 2'd3
    } act_e;

    localparam logic [3:0] REG_CTRL = 4'd0;
    localparam logic [3:0] REG_XLO  = 4'd1;
    localparam logic [3:0] REG_XHI  = 4'd2;
    localparam logic [3:0] REG_YLO  = 4'd3;
    localparam logic [3:0] REG_YHI  = 4'd4;
    localparam logic [3:0] REG_XHOT = 4'd5;
    localparam logic [3:0] REG_YHOT = 4'd6;
    localparam logic [3:0] REG_C1R  = 4'd7;
    localparam logic [3:0] REG_C1G  = 4'd8;
    localparam logic [3:0] REG_C1B  = 4'd9;
    localparam logic [3:0] REG_C2R  = 4'd10;
    localparam logic [3:0] REG_C2G  = 4'd11;
    localparam logic [3:0] REG_C2B  = 4'd12;
    localparam logic [3:0] REG_PTR  = 4'd13;
    localparam logic [3:0] REG_DATA = 4'd14;

    function automatic act_e decode_code(input logic mode, input logic [1:0] code);
        act_e a;
        if (!mode) begin
            case (code)
                2'b00:   a = ACT_COL2;
                2'b01:   a = ACT_COL1;
                2'b10:   a = ACT_PASS;
                default: a = ACT_INV;
            endcase
        end else begin
            case (code)
                2'b00:   a = ACT_PASS;
                2'b01:   a = ACT_INV;
                2'b10:   a = ACT_COL1;
                default: a = ACT_COL2;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/cursor_regs.sv
module cursor_regs #(
    parameter int PW    = 10,
    parameter int HW    = 5,
    parameter int BM_AW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic [BM_AW-1:0] rd_addr,
    output logic [7:0]       rd_data,
    output logic             cfg_en,
    output logic             cfg_mode,
    output logic             cfg_ilace,
    output logic [PW-1:0]    xpos,
    output logic [PW-1:0]    ypos,
    output logic [HW-1:0]    xhot,
    output logic [HW-1:0]    yhot,
    output logic [23:0]      col1,
    output logic [23:0]      col2,
    output logic [BM_AW-1:0] bm_ptr
);
    import cursor_pkg::*;

    localparam int BM_BYTES = 1 << BM_AW;

    typedef struct packed {
        logic             en;
        logic             mode;
        logic             ilace;
        logic [PW-1:0]    xpos;
        logic [PW-1:0]    ypos;
        logic [HW-1:0]    xhot;
        logic [HW-1:0]    yhot;
        logic [23:0]      col1;
        logic [23:0]      col2;
        logic [BM_AW-1:0] ptr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [7:0] bm_mem [BM_BYTES];

    always_comb begin
        cfg_d = cfg_q;
        if (reg_we) begin
            case (reg_addr)
                REG_CTRL: {cfg_d.ilace, cfg_d.mode, cfg_d.en} = reg_wdata[2:0];
                REG_XLO:  cfg_d.xpos[7:0]    = reg_wdata;
                REG_XHI:  cfg_d.xpos[PW-1:8] = reg_wdata[PW-9:0];
                REG_YLO:  cfg_d.ypos[7:0]    = reg_wdata;
                REG_YHI:  cfg_d.ypos[PW-1:8] = reg_wdata[PW-9:0];
                REG_XHOT: cfg_d.xhot = reg_wdata[HW-1:0];
                REG_YHOT: cfg_d.yhot = reg_wdata[HW-1:0];
                REG_C1R:  cfg_d.col1[23:16] = reg_wdata;
                REG_C1G:  cfg_d.col1[15:8]  = reg_wdata;
                REG_C1B:  cfg_d.col1[7:0]   = reg_wdata;
                REG_C2R:  cfg_d.col2[23:16] = reg_wdata;
                REG_C2G:  cfg_d.col2[15:8]  = reg_wdata;
                REG_C2B:  cfg_d.col2[7:0]   = reg_wdata;
                REG_PTR:  cfg_d.ptr = reg_wdata[BM_AW-1:0];
                REG_DATA: cfg_d.ptr = cfg_q.ptr + 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // image store: plain RAM, no reset
    always_ff @(posedge clk) begin
        if (reg_we && reg_addr == REG_DATA) bm_mem[cfg_q.ptr] <= reg_wdata;
    end

    assign rd_data   = bm_mem[rd_addr];
    assign cfg_en    = cfg_q.en;
    assign cfg_mode  = cfg_q.mode;
    assign cfg_ilace = cfg_q.ilace;
    assign xpos      = cfg_q.xpos;
    assign ypos      = cfg_q.ypos;
    assign xhot      = cfg_q.xhot;
    assign yhot      = cfg_q.yhot;
    assign col1      = cfg_q.col1;
    assign col2      = cfg_q.col2;
    assign bm_ptr    = cfg_q.ptr;
endmodule

// File: rtl/cursor_locate.sv
module cursor_locate #(
    parameter int PW    = 10,
    parameter int CDIM  = 32,
    parameter int HW    = 5,
    parameter int BM_AW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic             line_start,
    input  logic             frame_start,
    input  logic             ilace,
    input  logic [PW-1:0]    xpos,
    input  logic [PW-1:0]    ypos,
    input  logic [HW-1:0]    xhot,
    input  logic [HW-1:0]    yhot,
    output logic             hit,
    output logic [BM_AW-1:0] bm_addr,
    output logic [1:0]       sub
);
    localparam int CAW = $clog2(CDIM);
    localparam int LW  = PW + 1;
    localparam int SW  = PW + 3;

    typedef struct packed {
        logic [LW-1:0] x;
        logic [LW-1:0] y;
        logic          field;
    } pos_t;

    pos_t pos_d, pos_q;
    logic [LW-1:0] cur_x, cur_y;
    logic          cur_f;
    logic [LW:0]   scr_y;
    logic [SW-1:0] off_x, off_y;

    always_comb begin
        cur_x = (line_start || frame_start) ? '0 : pos_q.x;
        cur_y = frame_start ? '0 : (line_start ? pos_q.y + 1'b1 : pos_q.y);
        cur_f = frame_start ? ~pos_q.field : pos_q.field;

        pos_d = pos_q;
        if (pix_valid) begin
            pos_d.x     = cur_x + 1'b1;
            pos_d.y     = cur_y;
            pos_d.field = cur_f;
        end

        scr_y = ilace ? {cur_y, cur_f} : {1'b0, cur_y};
        // negative offsets wrap to large unsigned values and fail the range test
        off_x = SW'(cur_x) + SW'(xhot) - SW'(xpos);
        off_y = SW'(scr_y) + SW'(yhot) - SW'(ypos);
        hit   = (off_x < SW'(CDIM)) && (off_y < SW'(CDIM));
        bm_addr = {off_y[CAW-1:0], off_x[CAW-1:2]};
        sub     = off_x[1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '{x: '0, y: '0, field: 1'b1};
        else        pos_q <= pos_d;
    end
endmodule

// File: rtl/cursor_blend.sv
module cursor_blend (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pix_valid,
    input  logic [23:0] pix_rgb,
    input  logic        en,
    input  logic        mode,
    input  logic        hit,
    input  logic [1:0]  sub,
    input  logic [7:0]  bm_byte,
    input  logic [23:0] col1,
    input  logic [23:0] col2,
    output logic        out_valid,
    output logic [23:0] out_rgb
);
    import cursor_pkg::*;

    typedef struct packed {
        logic        vld;
        logic [23:0] rgb;
    } out_t;

    out_t o_d, o_q;
    logic [1:0]  code;
    act_e        act;
    logic [23:0] sel;

    always_comb begin
        code = 2'(bm_byte >> {~sub, 1'b0});
        act  = (en && hit) ? decode_code(mode, code) : ACT_PASS;
        case (act)
            ACT_INV:  sel = ~pix_rgb;
            ACT_COL1: sel = col1;
            ACT_COL2: sel = col2;
            default:  sel = pix_rgb;
        endcase
        o_d     = o_q;
        o_d.vld = pix_valid;
        if (pix_valid) o_d.rgb = sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid = o_q.vld;
    assign out_rgb   = o_q.rgb;
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
    parameter int PW   = 10,
    parameter int CDIM = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    input  logic        pix_valid,
    input  logic        line_start,
    input  logic        frame_start,
    input  logic [23:0] pix_rgb,
    output logic        out_valid,
    output logic [23:0] out_rgb
);
    localparam int HW    = $clog2(CDIM);
    localparam int BM_AW = 2 * HW - 2;

    logic             cfg_en, cfg_mode, cfg_ilace;
    logic [PW-1:0]    xpos, ypos;
    logic [HW-1:0]    xhot, yhot;
    logic [23:0]      col1, col2;
    logic [BM_AW-1:0] bm_ptr, bm_addr;
    logic [7:0]       bm_byte;
    logic             hit;
    logic [1:0]       sub;

    cursor_regs #(.PW(PW), .HW(HW), .BM_AW(BM_AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .rd_addr(bm_addr), .rd_data(bm_byte),
        .cfg_en(cfg_en), .cfg_mode(cfg_mode), .cfg_ilace(cfg_ilace),
        .xpos(xpos), .ypos(ypos), .xhot(xhot), .yhot(yhot),
        .col1(col1), .col2(col2), .bm_ptr(bm_ptr)
    );

    cursor_locate #(.PW(PW), .CDIM(CDIM), .HW(HW), .BM_AW(BM_AW)) u_locate (
        .clk(clk), .rst_n(rst_n),
        .pix_valid(pix_valid), .line_start(line_start), .frame_start(frame_start),
        .ilace(cfg_ilace), .xpos(xpos), .ypos(ypos), .xhot(xhot), .yhot(yhot),
        .hit(hit), .bm_addr(bm_addr), .sub(sub)
    );

    cursor_blend u_blend (
        .clk(clk), .rst_n(rst_n),
        .pix_valid(pix_valid), .pix_rgb(pix_rgb),
        .en(cfg_en), .mode(cfg_mode), .hit(hit), .sub(sub), .bm_byte(bm_byte),
        .col1(col1), .col2(col2),
        .out_valid(out_valid), .out_rgb(out_rgb)
    );
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
    parameter int BM_AW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [3:0]       reg_addr,
    input logic [7:0]       reg_wdata,
    input logic             pix_valid,
    input logic [23:0]      pix_rgb,
    input logic             out_valid,
    input logic [23:0]      out_rgb,
    input logic             cfg_en,
    input logic [23:0]      col1,
    input logic [23:0]      col2,
    input logic [BM_AW-1:0] bm_ptr
);
    import cursor_pkg::*;

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);

    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> (!out_valid && $stable(out_rgb)));

    assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !cfg_en) |=> (out_rgb == $past(pix_rgb)));

    // R4 / R5 / R6: every output pixel is one of the four permitted choices
    assert_choice_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> (out_rgb == $past(pix_rgb) || out_rgb == ~$past(pix_rgb) ||
                       out_rgb == $past(col1)    || out_rgb == $past(col2)));

    assert_ptr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == REG_DATA) |=> (bm_ptr == $past(bm_ptr) + 1'b1));

    assert_ptr_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == REG_PTR) |=> (bm_ptr == $past(reg_wdata[BM_AW-1:0])));
endmodule

bind cursor_overlay cursor_overlay_chk #(.BM_AW(BM_AW)) i_chk (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .pix_valid(pix_valid), .pix_rgb(pix_rgb),
    .out_valid(out_valid), .out_rgb(out_rgb),
    .cfg_en(cfg_en), .col1(col1), .col2(col2), .bm_ptr(bm_ptr)
);

// File: tb/test_cursor_overlay.sv
module test_cursor_overlay;

    localparam int W = 40;
    localparam int H = 36;
    localparam logic [23:0] C1 = 24'hFF2010;
    localparam logic [23:0] C2 = 24'h0033CC;

    typedef struct packed {
        logic       en;
        logic       mode;
        logic       il;
        logic [9:0] xp;
        logic [9:0] yp;
        logic [4:0] xh;
        logic [4:0] yh;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b1, 1'b0, 1'b0, 10'd10,  10'd4,   5'd0,  5'd0 },
        '{1'b1, 1'b1, 1'b0, 10'd12,  10'd8,   5'd3,  5'd2 },
        '{1'b1, 1'b0, 1'b0, 10'd2,   10'd1,   5'd6,  5'd9 },
        '{1'b1, 1'b0, 1'b1, 10'd5,   10'd10,  5'd1,  5'd1 },
        '{1'b0, 1'b0, 1'b0, 10'd10,  10'd4,   5'd0,  5'd0 },
        '{1'b1, 1'b1, 1'b0, 10'd31,  10'd31,  5'd31, 5'd31},
        '{1'b1, 1'b0, 1'b0, 10'd700, 10'd500, 5'd4,  5'd4 }
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        pix_valid = 1'b0;
    logic        line_start = 1'b0;
    logic        frame_start = 1'b0;
    logic [23:0] pix_rgb = '0;
    logic        out_valid;
    logic [23:0] out_rgb;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0]  bm_ref [256];
    logic [7:0]  ref_ptr = '0;
    vec_t        cfg = '0;
    int          nframes = 0;
    logic        prev_v = 1'b0;
    logic [23:0] prev_e = '0;

    cursor_overlay i_cursor_overlay (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .pix_valid(pix_valid), .line_start(line_start), .frame_start(frame_start),
        .pix_rgb(pix_rgb), .out_valid(out_valid), .out_rgb(out_rgb)
    );

    always #2 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: run did not finish, actual=%0d expected<150000 cycles", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [24:0] act, input logic [24:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        if (a == 4'd13) ref_ptr = d;
        if (a == 4'd14) begin bm_ref[ref_ptr] = d; ref_ptr = ref_ptr + 8'd1; end
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic logic [1:0] pat(input int r, input int c);
        return 2'((r ^ c ^ (c >> 2) ^ (r >> 3)) & 3);
    endfunction

    function automatic logic [23:0] in_pix(input int x, input int y);
        return {8'(x * 5), 8'(y * 7), 8'(8'h5A ^ x)};
    endfunction

    // reference per R4..R9, R11, R12
    function automatic logic [23:0] exp_pix(input int x, input int y, input int f);
        int ly, dx, dy;
        logic [7:0] b;
        logic [1:0] code;
        logic [23:0] p;
        p  = in_pix(x, y);
        ly = cfg.il ? 2 * y + f : y;
        dx = x + int'(cfg.xh) - int'(cfg.xp);
        dy = ly + int'(cfg.yh) - int'(cfg.yp);
        if (!cfg.en || dx < 0 || dx > 31 || dy < 0 || dy > 31) return p;
        b = bm_ref[dy * 8 + dx / 4];
        code = 2'(b >> (6 - 2 * (dx % 4)));
        if (!cfg.mode) begin
            case (code)
                2'b00: return C2;
                2'b01: return C1;
                2'b10: return p;
                default: return ~p;
            endcase
        end else begin
            case (code)
                2'b00: return p;
                2'b01: return ~p;
                2'b10: return C1;
                default: return C2;
            endcase
        end
    endfunction

    // one cycle: check output of the previous cycle, then drive the next input
    task automatic step(input logic v, input logic ls, input logic fs,
                        input logic [23:0] rgb, input logic [23:0] e, input string req);
        @(negedge clk);
        chk(out_valid == prev_v && out_rgb == prev_e, req, {out_valid, out_rgb}, {prev_v, prev_e});
        pix_valid = v; line_start = ls; frame_start = fs; pix_rgb = rgb;
        prev_v = v;
        if (v) prev_e = e;
    endtask

    task automatic frame(input string req);
        int f;
        f = nframes & 1;
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < W; x++)
                step(1'b1, x == 0, x == 0 && y == 0, in_pix(x, y), exp_pix(x, y, f), req);
            step(1'b0, 1'b0, 1'b0, 24'h0, 24'h0, "R2 idle hold");
        end
        nframes++;
    endtask

    task automatic set_cfg(input vec_t v);
        cfg = v;
        wr(4'd0, {5'd0, v.il, v.mode, v.en});
        wr(4'd1, v.xp[7:0]); wr(4'd2, {6'd0, v.xp[9:8]});
        wr(4'd3, v.yp[7:0]); wr(4'd4, {6'd0, v.yp[9:8]});
        wr(4'd5, {3'd0, v.xh}); wr(4'd6, {3'd0, v.yh});
    endtask

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R4 R7 R9 R12";
            1: return "R5 R7";
            2: return "R8 clip";
            3: return "R11 interlace";
            4: return "R3 bypass";
            5: return "R5 R7 hot spot 31";
            default: return "R7 R13 high position bits";
        endcase
    endfunction

    initial begin
        logic [7:0] b;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && out_rgb == 24'h0, "R1 reset outputs",
            {out_valid, out_rgb}, 25'h0);
        rst_n = 1'b1;
        // R1: control resets to 0, so the overlay is disabled
        frame("R1 disabled after reset");

        // colours, R13
        wr(4'd7, C1[23:16]); wr(4'd8, C1[15:8]); wr(4'd9, C1[7:0]);
        wr(4'd10, C2[23:16]); wr(4'd11, C2[15:8]); wr(4'd12, C2[7:0]);

        // image load, R9 R10
        wr(4'd13, 8'd0);
        for (int a = 0; a < 256; a++) begin
            for (int i = 0; i < 4; i++) b[7 - 2 * i -: 2] = pat(a / 8, (a % 8) * 4 + i);
            wr(4'd14, b);
        end

        // vector table walk
        for (int i = 0; i < 7; i++) begin
            set_cfg(VECS[i]);
            frame(vec_tag(i));
            frame(vec_tag(i));
        end

        // R10: pointer wrap 255 -> 0, then show corners of the image
        wr(4'd13, 8'd254);
        wr(4'd14, 8'h1B); wr(4'd14, 8'hE4); wr(4'd14, 8'h72);
        set_cfg('{1'b1, 1'b0, 1'b0, 10'd0, 10'd0, 5'd0, 5'd0});
        frame("R10 pointer wrap");

        // R6: inversion of a lone pixel, R2: hold over idle cycles
        wr(4'd13, 8'd0); wr(4'd14, 8'hFF);
        step(1'b1, 1'b1, 1'b1, 24'h12F0A5, 24'hED0F5A, "R6 invert");
        step(1'b0, 1'b0, 1'b0, 24'h0, 24'h0, "R6 invert");
        step(1'b0, 1'b0, 1'b0, 24'hFFFFFF, 24'h0, "R2 hold");
        step(1'b0, 1'b0, 1'b0, 24'h0, 24'h0, "R2 hold");
        nframes++;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule